// File: doc/BRIEF.md
# Pipeline Interlock Stall Detector

This block detects read-after-write hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no forwarding paths. It keeps the instruction words and valid bits of the decode, execute, memory and writeback slots. For every slot it decodes the opcode class and works out three things: which register the instruction writes, whether it writes at all, and which source fields it reads.

When the decode instruction reads a register that an older instruction in execute, memory or writeback is still due to write, the block raises `stall`. While `stall` is high the decode slot keeps its instruction, fetch must present the same word again, and an empty slot (a bubble) enters execute. The memory and writeback slots keep advancing, so the producer drains and the stall clears by itself.

Write-enable and read-enable are decoded per opcode class. As a result, a stall only happens for a real producer/consumer pair: a write to register 0 never stalls, and an unused field that happens to match never stalls.

Top module: `pil_interlock`

## Requirements
- R1: Fields are op = instr[31:26], rs = instr[25:21], rt = instr[20:16], rd = instr[15:11], func = instr[5:0]. The classes are: op 6'h00 is register ALU, except func 6'h08 (JR) and func 6'h09 (JALR). op 6'h08..6'h0F is ALUi. 6'h23 is LW, 6'h2B is SW, 6'h04 is BZ, 6'h02 is J and 6'h03 is JAL. Any other op neither reads nor writes.
- R2: The destination is rd for ALU, rt for ALUi and LW, and register 31 for JAL and JALR.
- R3: ALU, ALUi and LW write only when their destination is not register 0. JAL and JALR always write. No other class writes.
- R4: The rs field is read by ALU, ALUi, LW, SW, BZ, JR and JALR. It is not read by J or JAL.
- R5: The rt field is read only by ALU and SW.
- R6: `stall` is high when the valid decode instruction reads a field that equals the destination of a writing instruction in execute, memory or writeback. A producer directly ahead gives 3 stall cycles, one slot apart gives 2, and two slots apart gives 1.
- R7: During a stall the decode instruction is held and the execute slot becomes empty (`ex_valid` = 0). On the edge after the stall clears, the held instruction moves into execute.
- R8: Reset (synchronous, active high) clears every slot valid bit, so `stall` = 0 and `ex_valid` = 0. Empty slots, and words fetched with `fetch_valid` = 0, never cause a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word offered to decode |
| fetch_valid | input | 1 | The offered word is a real instruction |
| stall | output | 1 | Hold PC and decode; a bubble enters execute |
| ex_instr | output | 32 | Instruction now in execute (zero for a bubble) |
| ex_valid | output | 1 | Execute holds a real instruction |

## Verification
The assertions assume that fetch re-presents the same word for as long as `stall` is high. They also assume that an instruction word is only taken as real when `fetch_valid` is set. The bench keeps within this: it advances its instruction list only in cycles where it sees `stall` low, and it marks gaps with `fetch_valid` = 0. Register numbers in the random streams come from a small set, register 0 included, so that hazards, writes to register 0 and unused fields that match are all frequent.

// File: rtl/pil_pkg.sv
package pil_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int PEND     = 3;             // execute, memory, writeback
    localparam int SLOTS    = PEND + 1;      // plus decode
    localparam logic [REG_W-1:0] LINK_REG = REG_W'(31);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_BZ    = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] FN_JR    = 6'h08;
    localparam logic [5:0] FN_JALR  = 6'h09;

    typedef enum logic [3:0] {
        K_NONE, K_ALU, K_ALUI, K_LW, K_SW, K_BZ, K_J, K_JAL, K_JR, K_JALR
    } op_kind_e;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic             wr;
        logic [REG_W-1:0] src1;
        logic             rd1;
        logic [REG_W-1:0] src2;
        logic             rd2;
    } reg_use_t;

    function automatic op_kind_e classify(input logic [INSTR_W-1:0] w);
        logic [5:0] op;
        logic [5:0] fn;
        op = w[31:26];
        fn = w[5:0];
        if (op == OP_RTYPE) begin
            if (fn == FN_JR)        return K_JR;
            else if (fn == FN_JALR) return K_JALR;
            else                    return K_ALU;
        end
        if (op[5:3] == 3'b001)     return K_ALUI;
        case (op)
            OP_LW:   return K_LW;
            OP_SW:   return K_SW;
            OP_BZ:   return K_BZ;
            OP_J:    return K_J;
            OP_JAL:  return K_JAL;
            default: return K_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pil_decode.sv
module pil_decode
    import pil_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    output reg_use_t           use_o
);
    op_kind_e kind;

    always_comb begin
        kind        = classify(instr);
        use_o       = '0;
        use_o.src1  = instr[25:21];
        use_o.src2  = instr[20:16];
        case (kind)
            K_ALU: begin
                use_o.dst = instr[15:11];
                use_o.wr  = (instr[15:11] != '0);
                use_o.rd1 = 1'b1;
                use_o.rd2 = 1'b1;
            end
            K_ALUI, K_LW: begin
                use_o.dst = instr[20:16];
                use_o.wr  = (instr[20:16] != '0);
                use_o.rd1 = 1'b1;
            end
            K_SW: begin
                use_o.rd1 = 1'b1;
                use_o.rd2 = 1'b1;
            end
            K_BZ, K_JR: use_o.rd1 = 1'b1;
            K_JALR: begin
                use_o.dst = LINK_REG;
                use_o.wr  = 1'b1;
                use_o.rd1 = 1'b1;
            end
            K_JAL: begin
                use_o.dst = LINK_REG;
                use_o.wr  = 1'b1;
            end
            default: ;
        endcase
        if (!valid) begin
            use_o.wr  = 1'b0;
            use_o.rd1 = 1'b0;
            use_o.rd2 = 1'b0;
        end
    end

    // R3: a register-0 write is never flagged
    always_comb begin
        if (use_o.wr) p_no_r0_write_r3: assert (use_o.dst != '0);
    end
endmodule

// File: rtl/pil_stall.sv
module pil_stall
    import pil_pkg::*;
#(
    parameter int N_PEND = PEND
) (
    input  reg_use_t dec_use,
    input  reg_use_t pend_use [N_PEND],
    output logic     stall
);
    logic [N_PEND-1:0] hit1;
    logic [N_PEND-1:0] hit2;

    for (genvar i = 0; i < N_PEND; i++) begin : g_cmp
        assign hit1[i] = pend_use[i].wr && (pend_use[i].dst == dec_use.src1);
        assign hit2[i] = pend_use[i].wr && (pend_use[i].dst == dec_use.src2);
    end

    assign stall = ((|hit1) && dec_use.rd1) || ((|hit2) && dec_use.rd2);

    // R6: a stall always comes from a source the decode instruction reads
    always_comb begin
        if (stall) p_stall_has_reader_r6: assert (dec_use.rd1 || dec_use.rd2);
    end
endmodule

// File: rtl/pil_pipe.sv
module pil_pipe
    import pil_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [INSTR_W-1:0]              fetch_instr,
    input  logic                            fetch_valid,
    input  logic                            stall,
    output logic [SLOTS-1:0][INSTR_W-1:0]   slot_instr,
    output logic [SLOTS-1:0]                slot_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld   <= '0;
            slot_instr <= '0;
        end else begin
            for (int s = 2; s < SLOTS; s++) begin
                slot_instr[s] <= slot_instr[s-1];
                slot_vld[s]   <= slot_vld[s-1];
            end
            if (stall) begin
                slot_instr[1] <= '0;
                slot_vld[1]   <= 1'b0;
            end else begin
                slot_instr[1] <= slot_instr[0];
                slot_vld[1]   <= slot_vld[0];
                slot_instr[0] <= fetch_instr;
                slot_vld[0]   <= fetch_valid;
            end
        end
    end

    p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> !slot_vld[1]);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(slot_instr[0]) && slot_vld[0]));
    p_drain_r7: assert property (@(posedge clk) disable iff (rst)
        slot_vld[2] |=> slot_vld[3]);
    p_no_stall_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !slot_vld[0] |-> !stall);
endmodule

// File: rtl/pil_interlock.sv
module pil_interlock
    import pil_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         fetch_instr,
    input  logic                fetch_valid,
    output logic                stall,
    output logic [31:0]         ex_instr,
    output logic                ex_valid
);
    logic [SLOTS-1:0][INSTR_W-1:0] slot_instr;
    logic [SLOTS-1:0]              slot_vld;
    reg_use_t                      uses [SLOTS];
    reg_use_t                      pend [PEND];

    pil_pipe u_pipe (
        .clk         (clk),
        .rst         (rst),
        .fetch_instr (fetch_instr),
        .fetch_valid (fetch_valid),
        .stall       (stall),
        .slot_instr  (slot_instr),
        .slot_vld    (slot_vld)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        pil_decode u_dec (
            .instr (slot_instr[s]),
            .valid (slot_vld[s]),
            .use_o (uses[s])
        );
    end

    for (genvar p = 0; p < PEND; p++) begin : g_pend
        assign pend[p] = uses[p+1];
    end

    pil_stall #(.N_PEND(PEND)) u_stall (
        .dec_use  (uses[0]),
        .pend_use (pend),
        .stall    (stall)
    );

    assign ex_instr = slot_instr[1];
    assign ex_valid = slot_vld[1];
endmodule

// File: tb/pil_interlock_bench.sv
module pil_interlock_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_instr = '0;
    logic        fetch_valid = 1'b0;
    logic        stall;
    logic [31:0] ex_instr;
    logic        ex_valid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R6";

    logic [31:0] q_i [64];
    logic        q_v [64];
    int          qn;
    logic [31:0] m_i [4];
    logic        m_v [4];
    int          stall_cnt;

    pil_interlock u_pil_interlock (
        .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .fetch_valid(fetch_valid),
        .stall(stall), .ex_instr(ex_instr), .ex_valid(ex_valid)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rty(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] ity(input logic [5:0] op, input int rs, input int rt);
        return {op, 5'(rs), 5'(rt), 16'h0010};
    endfunction

    // bench-side decode written from R1..R5
    function automatic void bdec(input logic [31:0] w, input logic v,
                                 output int d, output bit we, output bit r1, output bit r2);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        d = 0; we = 0; r1 = 0; r2 = 0;
        if (op == 6'h00 && fn == 6'h08) r1 = 1;
        else if (op == 6'h00 && fn == 6'h09) begin r1 = 1; d = 31; we = 1; end
        else if (op == 6'h00) begin r1 = 1; r2 = 1; d = int'(w[15:11]); we = (d != 0); end
        else if ((op >= 6'h08 && op <= 6'h0F) || op == 6'h23) begin
            r1 = 1; d = int'(w[20:16]); we = (d != 0);
        end
        else if (op == 6'h2B) begin r1 = 1; r2 = 1; end
        else if (op == 6'h04) r1 = 1;
        else if (op == 6'h03) begin d = 31; we = 1; end
        if (!v) begin we = 0; r1 = 0; r2 = 0; end
    endfunction

    function automatic bit ref_stall();
        int dd; bit dw, a1, a2;
        bit s = 0;
        bdec(m_i[0], m_v[0], dd, dw, a1, a2);
        for (int k = 1; k < 4; k++) begin
            int pd; bit pw, x1, x2;
            bdec(m_i[k], m_v[k], pd, pw, x1, x2);
            if (pw && a1 && pd == int'(m_i[0][25:21])) s = 1;
            if (pw && a2 && pd == int'(m_i[0][20:16])) s = 1;
        end
        return s;
    endfunction

    task automatic do_reset();
        rst = 1'b1; fetch_valid = 1'b0; fetch_instr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin m_i[k] = '0; m_v[k] = 1'b0; end
    endtask

    // feed q_i/q_v, compare every cycle, drain at the end
    task automatic run_list();
        int idx = 0;
        int tail = 0;
        bit e;
        stall_cnt = 0;
        while (tail < 5) begin
            @(negedge clk);
            if (idx < qn) begin fetch_instr = q_i[idx]; fetch_valid = q_v[idx]; end
            else begin fetch_instr = '0; fetch_valid = 1'b0; tail++; end
            #1;
            e = ref_stall();
            chk({cur_req, " stall"}, 32'(stall), 32'(e));
            chk("R7 ex_valid", 32'(ex_valid), 32'(m_v[1]));
            if (m_v[1]) chk("R7 ex_instr", ex_instr, m_i[1]);
            if (stall) stall_cnt++;
            @(posedge clk);
            m_i[3] = m_i[2]; m_v[3] = m_v[2];
            m_i[2] = m_i[1]; m_v[2] = m_v[1];
            if (e) begin m_i[1] = '0; m_v[1] = 1'b0; end
            else begin
                m_i[1] = m_i[0]; m_v[1] = m_v[0];
                m_i[0] = fetch_instr; m_v[0] = fetch_valid;
                if (idx < qn) idx++;
            end
        end
    endtask

    task automatic pair(input string req, input logic [31:0] a, input logic [31:0] b,
                        input int gap, input int exp_stalls);
        cur_req = req;
        qn = 0;
        q_i[qn] = a; q_v[qn] = 1; qn++;
        for (int g = 0; g < gap; g++) begin q_i[qn] = rty(20, 21, 22, 6'h20); q_v[qn] = 1; qn++; end
        q_i[qn] = b; q_v[qn] = 1; qn++;
        run_list();
        chk({req, " stall count"}, 32'(stall_cnt), 32'(exp_stalls));
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R8 reset stall", 32'(stall), 32'd0);
        chk("R8 reset ex_valid", 32'(ex_valid), 32'd0);
    endtask

    task automatic t_alu_rs();   // R6 R2 producer directly ahead
        pair("R6", rty(0, 0, 1, 6'h20), rty(1, 2, 4, 6'h20), 0, 3);
    endtask
    task automatic t_distance(); // R6 producer in memory / writeback
        pair("R6", rty(0, 0, 1, 6'h20), rty(1, 2, 4, 6'h20), 1, 2);
        pair("R6", rty(0, 0, 1, 6'h20), rty(2, 1, 4, 6'h20), 2, 1);
        pair("R6", rty(0, 0, 1, 6'h20), rty(2, 3, 4, 6'h20), 3, 0);
    endtask
    task automatic t_sw_rt();    // R5 R2 ALUi writes rt, SW reads rt
        pair("R5", ity(6'h08, 0, 5), ity(6'h2B, 0, 5), 0, 3);
    endtask
    task automatic t_r0();       // R3 write to r0 never stalls
        pair("R3", rty(1, 2, 0, 6'h20), rty(0, 0, 4, 6'h20), 0, 0);
        pair("R3", ity(6'h23, 2, 0), ity(6'h2B, 0, 0), 0, 0);
    endtask
    task automatic t_link();     // R2 R3 R4 JAL writes r31, JR reads it
        pair("R4", {6'h03, 26'h10}, rty(31, 0, 0, 6'h08), 0, 3);
        pair("R1", rty(3, 0, 0, 6'h09), ity(6'h04, 31, 0), 0, 3);
    endtask
    task automatic t_unused();   // R5 R4 fields that match but are not read
        pair("R5", rty(0, 0, 7, 6'h20), ity(6'h08, 1, 7), 0, 0);
        pair("R4", rty(0, 0, 7, 6'h20), {6'h02, 5'd7, 21'h0}, 0, 0);
        pair("R4", rty(0, 0, 7, 6'h20), ity(6'h04, 7, 0), 0, 3);
    endtask
    task automatic t_invalid();  // R8 word with fetch_valid=0 never matches
        cur_req = "R8";
        qn = 0;
        q_i[0] = rty(0, 0, 1, 6'h20); q_v[0] = 0;
        q_i[1] = rty(1, 1, 4, 6'h20); q_v[1] = 1;
        qn = 2;
        run_list();
        chk("R8 stall count", 32'(stall_cnt), 32'd0);
    endtask

    task automatic t_random();   // R6 R1 mixed streams
        logic [5:0] ops [8] = '{6'h00, 6'h00, 6'h0A, 6'h23, 6'h2B, 6'h04, 6'h03, 6'h02};
        cur_req = "R6";
        for (int b = 0; b < 30; b++) begin
            qn = 60;
            for (int k = 0; k < 60; k++) begin
                int rs = $urandom_range(0, 3);
                int rt = $urandom_range(0, 3);
                int rd = $urandom_range(0, 3);
                int sel = $urandom_range(0, 9);
                if (sel < 8) begin
                    if (ops[sel] == 6'h00) q_i[k] = rty(rs, rt, rd, 6'h20);
                    else q_i[k] = ity(ops[sel], rs, rt);
                end else if (sel == 8) q_i[k] = rty(rs == 0 ? 31 : rs, rt, 0, 6'h08);
                else q_i[k] = rty(rs, rt, 0, 6'h09);
                q_v[k] = ($urandom_range(0, 7) != 0);
            end
            run_list();
        end
    endtask

    initial begin
        t_reset();
        t_alu_rs();
        t_distance();
        t_sw_rt();
        t_r0();
        t_link();
        t_unused();
        t_invalid();
        t_random();
        summary();
    end
endmodule